// File: doc/BRIEF.md
# NAND Flash Block Erase Sequencer

This block erases one block of a NAND flash device over an 8-bit asynchronous command, address and data bus. The host presents a block number and pulses a start input. The sequencer then writes the erase setup command, writes the row address cycles that select the block, and writes the erase confirm command. It then waits for the device's ready/busy line to come back high. When it does, the sequencer writes the read-status command, reads the status byte and reports pass or fail.

The host may abort a request at any point before the status read. The sequencer then writes the device reset command and waits for the device to come back ready. It also reports whether the block may have been left half erased. A busy timeout, set from an input, leads to the same reset recovery. Every strobe width is counted in controller clock cycles and fixed by parameters.

Top module: `nand_erase_seq`

## Requirements
- R1: After reset, and whenever no request is in progress, busy_o is 0, chip enable is high, write and read enables are high, and the command latch, address latch and data output enable are all low.
- R2: A request writes 60h with the command latch high, then the address cycles with the address latch high, then D0h with the command latch high. Each byte is taken by the device on the rising edge of write enable. The command latch and address latch are never high together.
- R3: With addr3_i = 1 the sequencer writes three address cycles. With addr3_i = 0 it writes two. The value is sampled at start.
- R4: The address bytes are the successive bytes, least significant first, of the row value formed by shifting the block number left by 6, which leaves the page bits zero. So byte 0 is {blk[1:0], 6'b0}, byte 1 is blk[9:2] and byte 2 is {7'b0, blk[10]}.
- R5: In every write cycle the data, command latch and address latch are driven with write enable high for SETUP_CYC cycles. Write enable is then low for WE_LO_CYC cycles and high again for WE_HI_CYC cycles with the data held. The data does not change while write enable is low.
- R6: After D0h the sequencer waits TWB_CYC cycles and then waits for ready/busy to be high before it writes 70h. While ready/busy is low, the only commands written are 70h or FFh.
- R7: The status byte is read with read enable low for WE_LO_CYC cycles. If status bit 6 is 0, another status byte is read. Read and write enables are never low together.
- R8: When status bit 6 is 1, done_o pulses for one cycle. pass_o is 1 if status bit 0 is 0, and fail_o is 1 if status bit 0 is 1. Both results hold until the next start.
- R9: An abort after D0h has been written makes the sequencer write FFh, wait for ready, then finish with invalid_o = 1 and pass_o = fail_o = 0.
- R10: An abort before D0h drops the rest of the sequence. The sequencer writes FFh, never writes D0h, and finishes with invalid_o = 0.
- R11: If ready/busy stays low for to_lim_i cycles while waiting for the erase (0 disables the limit), the sequencer sets timeout_o and invalid_o, writes FFh, and finishes with pass_o = 0.
- R12: A start pulse while busy_o is 1 has no effect on the request in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse for an erase request |
| blk_i | input | BLK_W | Block number to erase |
| addr3_i | input | 1 | 1 = three address cycles, 0 = two |
| abort_i | input | 1 | Abort request |
| to_lim_i | input | TO_W | Busy timeout limit in cycles, 0 = none |
| nand_rb_i | input | 1 | Device ready/busy, low = busy |
| nand_io_i | input | 8 | Data bus from device |
| nand_io_o | output | 8 | Data bus to device |
| nand_io_oe_o | output | 1 | Data bus output enable |
| nand_cle_o | output | 1 | Command latch enable |
| nand_ale_o | output | 1 | Address latch enable |
| nand_we_n_o | output | 1 | Write enable, active low |
| nand_re_n_o | output | 1 | Read enable, active low |
| nand_ce_n_o | output | 1 | Chip enable, active low |
| busy_o | output | 1 | Request in progress |
| done_o | output | 1 | One-cycle completion pulse |
| pass_o | output | 1 | Erase passed |
| fail_o | output | 1 | Device reported erase failure |
| timeout_o | output | 1 | Busy timeout occurred |
| invalid_o | output | 1 | Block contents may be partial |

## Verification
The erase is run with three and with two address cycles on block numbers with distinct bit patterns. This separates the cycle count from the byte packing, and a misplaced bit or a wrong shift shows up as a wrong byte. The status byte is varied between pass, fail and an initial not-ready value, which tells apart decoding of bit 0, decoding of bit 6 and the repeated read. Abort is applied once before and once after the confirm command, which separates the invalid flag from the plain abort. A long busy period against a short limit exercises the timeout path, and a second start in mid-request shows that the request in progress is not disturbed.

// File: rtl/nes_pkg.sv
package nes_pkg;

  localparam logic [7:0] OP_ERASE_SETUP = 8'h60;
  localparam logic [7:0] OP_ERASE_GO    = 8'hD0;
  localparam logic [7:0] OP_STATUS      = 8'h70;
  localparam logic [7:0] OP_RESET       = 8'hFF;

  localparam int ST_READY_BIT = 6;
  localparam int ST_FAIL_BIT  = 0;
  localparam int PAGE_BITS    = 6;

  typedef enum logic [3:0] {
    S_IDLE, S_SETUP, S_ADDR, S_CONF, S_TWB, S_WAIT,
    S_SCMD, S_SRD, S_RST, S_RTWB, S_RWAIT, S_FIN
  } seq_st_t;

  typedef enum logic [1:0] {BC_IDLE, BC_SET, BC_LO, BC_HI} bc_st_t;

  typedef struct packed {
    logic       rd;
    logic       cle;
    logic       ale;
    logic [7:0] data;
  } bus_req_t;

  // byte idx of the row address that selects a block; page bits are zero
  function automatic logic [7:0] row_byte(input logic [15:0] blk, input logic [1:0] idx);
    logic [31:0] row;
    row = {16'b0, blk} << PAGE_BITS;
    return row[idx*8 +: 8];
  endfunction

  function automatic logic stat_ready(input logic [7:0] s);
    return s[ST_READY_BIT];
  endfunction

  function automatic logic stat_failed(input logic [7:0] s);
    return s[ST_FAIL_BIT];
  endfunction

  function automatic bus_req_t wr_cmd(input logic [7:0] op);
    bus_req_t r;
    r.rd = 1'b0; r.cle = 1'b1; r.ale = 1'b0; r.data = op;
    return r;
  endfunction

  function automatic bus_req_t wr_addr(input logic [7:0] b);
    bus_req_t r;
    r.rd = 1'b0; r.cle = 1'b0; r.ale = 1'b1; r.data = b;
    return r;
  endfunction

  function automatic bus_req_t rd_byte();
    bus_req_t r;
    r.rd = 1'b1; r.cle = 1'b0; r.ale = 1'b0; r.data = 8'h00;
    return r;
  endfunction

endpackage

// File: rtl/nes_wait_timer.sv
module nes_wait_timer #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         en,
  input  logic [W-1:0] lim,
  output logic         hit
);
  logic [W-1:0] cnt;

  assign hit = en && (lim != '0) && (cnt == lim - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (clr)        cnt <= '0;
    else if (en && !hit) cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/nes_bus_cycle.sv
module nes_bus_cycle
  import nes_pkg::*;
#(
  parameter int SETUP_CYC = 2,
  parameter int LO_CYC    = 3,
  parameter int HI_CYC    = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       go,
  input  bus_req_t   req,
  input  logic [7:0] io_i,
  output logic [7:0] io_o,
  output logic       oe,
  output logic       cle,
  output logic       ale,
  output logic       we_n,
  output logic       re_n,
  output logic       done,
  output logic [7:0] rdata
);
  localparam int MAXC = (SETUP_CYC > LO_CYC) ? ((SETUP_CYC > HI_CYC) ? SETUP_CYC : HI_CYC)
                                             : ((LO_CYC > HI_CYC) ? LO_CYC : HI_CYC);
  localparam int CW = (MAXC < 2) ? 1 : $clog2(MAXC + 1);
  localparam logic [CW-1:0] SET_LAST = CW'(SETUP_CYC - 1);
  localparam logic [CW-1:0] LO_LAST  = CW'(LO_CYC - 1);
  localparam logic [CW-1:0] HI_LAST  = CW'(HI_CYC - 1);

  bc_st_t        bst;
  logic [CW-1:0] cnt;
  bus_req_t      rq;

  assign done = (bst == BC_HI) && (cnt == HI_LAST);
  assign oe   = (bst != BC_IDLE) && !rq.rd;
  assign cle  = oe && rq.cle;
  assign ale  = oe && rq.ale;
  assign io_o = oe ? rq.data : 8'h00;
  assign we_n = !((bst == BC_LO) && !rq.rd);
  assign re_n = !((bst == BC_LO) && rq.rd);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bst   <= BC_IDLE;
      cnt   <= '0;
      rq    <= '0;
      rdata <= 8'h00;
    end else begin
      case (bst)
        BC_IDLE: if (go) begin
          rq  <= req;
          cnt <= '0;
          bst <= req.rd ? BC_LO : BC_SET;
        end
        BC_SET: if (cnt == SET_LAST) begin
          bst <= BC_LO; cnt <= '0;
        end else cnt <= cnt + 1'b1;
        BC_LO: if (cnt == LO_LAST) begin
          bst <= BC_HI; cnt <= '0;
          if (rq.rd) rdata <= io_i;
        end else cnt <= cnt + 1'b1;
        default: if (cnt == HI_LAST) begin
          bst <= BC_IDLE; cnt <= '0;
        end else cnt <= cnt + 1'b1;
      endcase
    end
  end
endmodule

// File: rtl/nand_erase_seq.sv
module nand_erase_seq
  import nes_pkg::*;
#(
  parameter int BLK_W     = 11,
  parameter int TO_W      = 16,
  parameter int SETUP_CYC = 2,
  parameter int WE_LO_CYC = 3,
  parameter int WE_HI_CYC = 2,
  parameter int TWB_CYC   = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [BLK_W-1:0] blk_i,
  input  logic             addr3_i,
  input  logic             abort_i,
  input  logic [TO_W-1:0]  to_lim_i,
  input  logic             nand_rb_i,
  input  logic [7:0]       nand_io_i,
  output logic [7:0]       nand_io_o,
  output logic             nand_io_oe_o,
  output logic             nand_cle_o,
  output logic             nand_ale_o,
  output logic             nand_we_n_o,
  output logic             nand_re_n_o,
  output logic             nand_ce_n_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             pass_o,
  output logic             fail_o,
  output logic             timeout_o,
  output logic             invalid_o
);
  localparam logic [TO_W-1:0] TWB_LIM = TO_W'(TWB_CYC);

  seq_st_t          st, nst;
  logic [BLK_W-1:0] blk_q, nblk;
  logic             three_q, n3;
  logic [1:0]       idx_q, nidx;
  logic             abort_q, nab;
  logic             started_q, nstarted;
  logic             tmo_q, ntmo, pass_q, npass, fail_q, nfail, inv_q, ninv;
  logic             iss, go_q;
  bus_req_t         nreq, req_q;
  logic             want_rst;

  // internal events brought out for the checker
  logic             bus_done;
  logic [7:0]       stat_byte;
  logic             rb_s1, rb_s;
  logic             twb_hit, tmo_hit;
  logic             abort_ok;
  logic [1:0]       last_idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin rb_s1 <= 1'b1; rb_s <= 1'b1; end
    else begin rb_s1 <= nand_rb_i; rb_s <= rb_s1; end
  end

  nes_bus_cycle #(.SETUP_CYC(SETUP_CYC), .LO_CYC(WE_LO_CYC), .HI_CYC(WE_HI_CYC)) u_bus (
    .clk(clk), .rst_n(rst_n), .go(go_q), .req(req_q), .io_i(nand_io_i),
    .io_o(nand_io_o), .oe(nand_io_oe_o), .cle(nand_cle_o), .ale(nand_ale_o),
    .we_n(nand_we_n_o), .re_n(nand_re_n_o), .done(bus_done), .rdata(stat_byte)
  );

  nes_wait_timer #(.W(TO_W)) u_twb (
    .clk(clk), .rst_n(rst_n),
    .clr(!(st == S_TWB || st == S_RTWB)),
    .en(st == S_TWB || st == S_RTWB),
    .lim(TWB_LIM), .hit(twb_hit)
  );

  nes_wait_timer #(.W(TO_W)) u_tmo (
    .clk(clk), .rst_n(rst_n),
    .clr(st != S_WAIT),
    .en(st == S_WAIT && !rb_s),
    .lim(to_lim_i), .hit(tmo_hit)
  );

  assign abort_ok = (st == S_SETUP) || (st == S_ADDR) || (st == S_CONF) ||
                    (st == S_TWB)   || (st == S_WAIT);
  assign last_idx = three_q ? 2'd2 : 2'd1;

  always_comb begin
    nst = st; iss = 1'b0; nreq = '0; want_rst = 1'b0;
    nblk = blk_q; n3 = three_q; nidx = idx_q; nab = abort_q;
    nstarted = started_q; ntmo = tmo_q; npass = pass_q; nfail = fail_q; ninv = inv_q;
    if (abort_ok && abort_i) nab = 1'b1;
    case (st)
      S_IDLE: if (start_i) begin
        nst = S_SETUP; iss = 1'b1; nreq = wr_cmd(OP_ERASE_SETUP);
        nblk = blk_i; n3 = addr3_i; nidx = 2'd0; nab = 1'b0; nstarted = 1'b0;
        ntmo = 1'b0; npass = 1'b0; nfail = 1'b0; ninv = 1'b0;
      end
      S_SETUP: if (bus_done) begin
        if (nab) want_rst = 1'b1;
        else begin
          nst = S_ADDR; iss = 1'b1; nidx = 2'd0;
          nreq = wr_addr(row_byte(16'(blk_q), 2'd0));
        end
      end
      S_ADDR: if (bus_done) begin
        if (nab) want_rst = 1'b1;
        else if (idx_q == last_idx) begin
          nst = S_CONF; iss = 1'b1; nreq = wr_cmd(OP_ERASE_GO);
        end else begin
          nidx = idx_q + 2'd1; iss = 1'b1;
          nreq = wr_addr(row_byte(16'(blk_q), idx_q + 2'd1));
        end
      end
      S_CONF: if (bus_done) begin
        nstarted = 1'b1; nst = S_TWB;
      end
      S_TWB: begin
        if (nab) want_rst = 1'b1;
        else if (twb_hit) nst = S_WAIT;
      end
      S_WAIT: begin
        if (nab) want_rst = 1'b1;
        else if (rb_s) begin
          nst = S_SCMD; iss = 1'b1; nreq = wr_cmd(OP_STATUS);
        end else if (tmo_hit) begin
          ntmo = 1'b1; want_rst = 1'b1;
        end
      end
      S_SCMD: if (bus_done) begin
        nst = S_SRD; iss = 1'b1; nreq = rd_byte();
      end
      S_SRD: if (bus_done) begin
        if (!stat_ready(stat_byte)) begin
          iss = 1'b1; nreq = rd_byte();
        end else begin
          nfail = stat_failed(stat_byte);
          npass = !stat_failed(stat_byte);
          nst = S_FIN;
        end
      end
      S_RST:   if (bus_done) nst = S_RTWB;
      S_RTWB:  if (twb_hit) nst = S_RWAIT;
      S_RWAIT: if (rb_s) nst = S_FIN;
      default: nst = S_IDLE;
    endcase
    if (want_rst) begin
      nst = S_RST; iss = 1'b1; nreq = wr_cmd(OP_RESET); ninv = started_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; go_q <= 1'b0; req_q <= '0;
      blk_q <= '0; three_q <= 1'b0; idx_q <= 2'd0; abort_q <= 1'b0;
      started_q <= 1'b0; tmo_q <= 1'b0; pass_q <= 1'b0; fail_q <= 1'b0; inv_q <= 1'b0;
    end else begin
      st <= nst; go_q <= iss;
      if (iss) req_q <= nreq;
      blk_q <= nblk; three_q <= n3; idx_q <= nidx; abort_q <= nab;
      started_q <= nstarted; tmo_q <= ntmo; pass_q <= npass; fail_q <= nfail; inv_q <= ninv;
    end
  end

  assign busy_o      = (st != S_IDLE);
  assign nand_ce_n_o = !busy_o;
  assign done_o      = (st == S_FIN);
  assign pass_o      = pass_q;
  assign fail_o      = fail_q;
  assign timeout_o   = tmo_q;
  assign invalid_o   = inv_q;
endmodule

// File: rtl/nes_chk.sv
module nes_chk #(
  parameter int WE_LO_CYC = 3
) (
  input logic       clk,
  input logic       rst_n,
  input logic       we_n,
  input logic       re_n,
  input logic       cle,
  input logic       ale,
  input logic       oe,
  input logic [7:0] io_o,
  input logic       rb,
  input logic       busy,
  input logic       done,
  input logic       pass,
  input logic       fail,
  input logic       tmo,
  input logic       inval,
  input logic       bus_done
);
  logic [7:0] lo_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    lo_cnt <= 8'd0;
    else if (!we_n) lo_cnt <= lo_cnt + 8'd1;
    else           lo_cnt <= 8'd0;
  end

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (we_n && re_n && !cle && !ale && !oe));

  assert_latch_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(cle && ale));

  assert_we_width_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(we_n) |-> (lo_cnt == 8'(WE_LO_CYC)));

  assert_data_steady_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!we_n && $past(!we_n)) |-> $stable(io_o));

  assert_busy_cmds_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!rb && cle && !we_n) |-> (io_o == 8'h70 || io_o == 8'hFF));

  assert_strobe_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(!we_n && !re_n));

  assert_cycle_end_R7: assert property (@(posedge clk) disable iff (!rst_n)
    bus_done |-> (we_n && re_n));

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_result_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(pass && fail));

  assert_invalid_nopass_R9: assert property (@(posedge clk) disable iff (!rst_n)
    inval |-> !pass);

  assert_timeout_nopass_R11: assert property (@(posedge clk) disable iff (!rst_n)
    tmo |-> (!pass && inval));
endmodule

bind nand_erase_seq nes_chk #(.WE_LO_CYC(WE_LO_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .we_n(nand_we_n_o), .re_n(nand_re_n_o),
  .cle(nand_cle_o), .ale(nand_ale_o), .oe(nand_io_oe_o), .io_o(nand_io_o),
  .rb(nand_rb_i), .busy(busy_o), .done(done_o), .pass(pass_o), .fail(fail_o),
  .tmo(timeout_o), .inval(invalid_o), .bus_done(bus_done)
);

// File: tb/nand_erase_seq_tb.sv
`timescale 1ns/1ps
module nand_erase_seq_tb;
  localparam int SETUP = 2, WLO = 3, WHI = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, addr3 = 1'b0, abort = 1'b0;
  logic [10:0] blk = '0;
  logic [15:0] lim = '0;
  logic rb;
  logic [7:0] io_i, io_o;
  logic oe, cle, ale, we_n, re_n, ce_n, busy, done, pass, fail, tmo, inval;

  always #2.5 clk = ~clk;

  nand_erase_seq #(.BLK_W(11), .TO_W(16), .SETUP_CYC(SETUP), .WE_LO_CYC(WLO),
                   .WE_HI_CYC(WHI), .TWB_CYC(4)) u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start), .blk_i(blk), .addr3_i(addr3),
    .abort_i(abort), .to_lim_i(lim), .nand_rb_i(rb), .nand_io_i(io_i),
    .nand_io_o(io_o), .nand_io_oe_o(oe), .nand_cle_o(cle), .nand_ale_o(ale),
    .nand_we_n_o(we_n), .nand_re_n_o(re_n), .nand_ce_n_o(ce_n), .busy_o(busy),
    .done_o(done), .pass_o(pass), .fail_o(fail), .timeout_o(tmo), .invalid_o(inval)
  );

  int total = 0, bad = 0;

  // device model parameters set by tasks
  int  erase_len = 40;
  int  notrdy_n  = 0;
  int  rd_base   = 0;
  logic fail_bit = 1'b0;

  // device model state, written only by the model process
  logic [9:0] log_b [0:63];
  int  log_n = 0, rd_count = 0, busy_cnt = 0, cyc = 0;
  int  rb_rise_cyc = 0, st_cmd_cyc = 0;
  logic we_prev = 1'b1, re_prev = 1'b1;
  int  pre_run = 0, lo_run = 0, mon_err = 0, mon_falls = 0;

  assign rb   = (busy_cnt == 0);
  assign io_i = re_n ? 8'h00 :
                ((((rd_count - rd_base) < notrdy_n) ? 8'h00 : 8'h40) | {7'b0, fail_bit});

  always @(negedge clk) begin
    cyc <= cyc + 1;
    we_prev <= we_n;
    re_prev <= re_n;
    if (busy_cnt == 1) rb_rise_cyc <= cyc;
    if (busy_cnt > 0) busy_cnt <= busy_cnt - 1;
    if (!re_prev && re_n) rd_count <= rd_count + 1;
    if (oe && we_n) pre_run <= pre_run + 1; else pre_run <= 0;
    if (!we_n) lo_run <= lo_run + 1; else lo_run <= 0;
    if (we_prev && !we_n) begin
      mon_falls <= mon_falls + 1;
      if (pre_run != SETUP) mon_err <= mon_err + 1;
    end
    if (!we_prev && we_n) begin
      if (lo_run != WLO) mon_err <= mon_err + 1;
      if (log_n < 64) log_b[log_n] <= {cle, ale, io_o};
      log_n <= log_n + 1;
      if (cle && io_o == 8'hD0) busy_cnt <= erase_len;
      if (cle && io_o == 8'hFF) busy_cnt <= 6;
      if (cle && io_o == 8'h70) st_cmd_cyc <= cyc;
    end
  end

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_abyte(input logic [10:0] b, input int i);
    logic [23:0] row;
    row = {7'b0, b, 6'b000000};
    return row[8*i +: 8];
  endfunction

  task automatic pulse_start();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic wait_done(output logic got);
    got = 1'b0;
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      if (done) begin got = 1'b1; break; end
    end
  endtask

  task automatic setup_req(input logic [10:0] b, input logic a3, input int l,
                           input int el, input int nr, input logic fb);
    @(negedge clk);
    blk = b; addr3 = a3; lim = 16'(l); erase_len = el; notrdy_n = nr;
    fail_bit = fb; rd_base = rd_count;
  endtask

  task automatic t_reset();
    chk(!busy && ce_n && we_n && re_n && !cle && !ale && !oe, "R1 idle strobes",
        {busy, ce_n, we_n, re_n, cle, ale, oe}, 7'b0111000);
    chk(!done && !pass && !fail, "R1 results clear", {done, pass, fail}, 0);
  endtask

  task automatic t_full(input logic [10:0] b, input logic a3, input logic fb, input int nr);
    int base, rd0, na;
    logic got;
    setup_req(b, a3, 0, 40, nr, fb);
    base = log_n; rd0 = rd_count; na = a3 ? 3 : 2;
    pulse_start();
    chk(busy && !ce_n, "R1 busy during request", busy, 1);
    wait_done(got);
    chk(got, "R8 done seen", got, 1);
    chk(log_n - base == na + 3, "R3 byte count", log_n - base, na + 3);
    chk(log_b[base] == {2'b10, 8'h60}, "R2 setup cmd", log_b[base], {2'b10, 8'h60});
    for (int i = 0; i < na; i++)
      chk(log_b[base+1+i] == {2'b01, exp_abyte(b, i)}, "R4 address byte",
          log_b[base+1+i], {2'b01, exp_abyte(b, i)});
    chk(log_b[base+1+na] == {2'b10, 8'hD0}, "R2 confirm cmd", log_b[base+1+na], {2'b10, 8'hD0});
    chk(log_b[base+2+na] == {2'b10, 8'h70}, "R6 status cmd", log_b[base+2+na], {2'b10, 8'h70});
    chk(st_cmd_cyc > rb_rise_cyc, "R6 status after ready", st_cmd_cyc, rb_rise_cyc);
    chk(rd_count - rd0 == nr + 1, "R7 status reads", rd_count - rd0, nr + 1);
    chk(pass == !fb && fail == fb, "R8 result", {pass, fail}, {!fb, fb});
    chk(!inval && !tmo, "R8 no error flags", {inval, tmo}, 0);
    repeat (5) @(negedge clk);
    chk(pass == !fb && fail == fb && !busy, "R8 result held", {pass, fail, busy}, {!fb, fb, 1'b0});
  endtask

  task automatic t_abort_busy();
    int base;
    logic got;
    setup_req(11'h3F0, 1'b1, 0, 500, 0, 1'b0);
    base = log_n;
    pulse_start();
    for (int i = 0; i < 2000 && rb; i++) @(negedge clk);
    repeat (10) @(negedge clk);
    abort = 1'b1; @(negedge clk); abort = 1'b0;
    wait_done(got);
    chk(got, "R9 done after abort", got, 1);
    chk(log_b[base+4] == {2'b10, 8'hD0}, "R9 confirm issued", log_b[base+4], {2'b10, 8'hD0});
    chk(log_n - base == 6 && log_b[base+5] == {2'b10, 8'hFF}, "R9 reset cmd",
        log_b[base+5], {2'b10, 8'hFF});
    chk(inval && !pass && !fail, "R9 invalid flag", {inval, pass, fail}, 3'b100);
  endtask

  task automatic t_abort_early();
    int base;
    logic got;
    setup_req(11'h155, 1'b1, 0, 40, 0, 1'b0);
    base = log_n;
    pulse_start();
    abort = 1'b1; @(negedge clk); abort = 1'b0;
    wait_done(got);
    chk(got, "R10 done after abort", got, 1);
    chk(log_n - base == 2, "R10 sequence dropped", log_n - base, 2);
    chk(log_b[base+1] == {2'b10, 8'hFF}, "R10 reset cmd", log_b[base+1], {2'b10, 8'hFF});
    chk(!inval && !pass && !fail, "R10 not invalid", {inval, pass, fail}, 0);
  endtask

  task automatic t_timeout();
    int base;
    logic got;
    setup_req(11'h0AA, 1'b0, 50, 1000, 0, 1'b0);
    base = log_n;
    pulse_start();
    wait_done(got);
    chk(got, "R11 done after timeout", got, 1);
    chk(tmo && inval && !pass, "R11 timeout flags", {tmo, inval, pass}, 3'b110);
    chk(log_b[base+log_n-base-1] == {2'b10, 8'hFF}, "R11 reset cmd",
        log_b[log_n-1], {2'b10, 8'hFF});
    repeat (1000) @(negedge clk);
  endtask

  task automatic t_start_ignored();
    int base;
    logic got;
    setup_req(11'h246, 1'b1, 0, 40, 0, 1'b0);
    base = log_n;
    pulse_start();
    repeat (8) @(negedge clk);
    blk = 11'h7FF; addr3 = 1'b0;
    start = 1'b1; @(negedge clk); start = 1'b0;
    wait_done(got);
    chk(log_n - base == 6, "R12 one request only", log_n - base, 6);
    chk(log_b[base+2] == {2'b01, exp_abyte(11'h246, 1)}, "R12 address kept",
        log_b[base+2], {2'b01, exp_abyte(11'h246, 1)});
    repeat (3) @(negedge clk);
    chk(!busy, "R12 no second request", busy, 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_full(11'h5A3, 1'b1, 1'b0, 0);
    t_full(11'h2C7, 1'b0, 1'b1, 0);
    t_full(11'h4D1, 1'b1, 1'b0, 2);
    t_abort_busy();
    t_abort_early();
    t_timeout();
    t_start_ignored();
    chk(mon_err == 0, "R5 setup and low widths", mon_err, 0);
    chk(mon_falls > 20, "R5 strobes observed", mon_falls, 21);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule